// File: doc/BRIEF.md
# ADC Offset Compensation Calibrator

This block finds the offset error of a 10-bit converter and removes it from later conversions. A calibration begins with a one-cycle start pulse. During calibration the converter input is assumed to be tied to half of its reference, so a perfect converter would return exactly mid-scale (512). The block first waits a settling interval, which is a parameter counted in clock cycles. Sample strobes that arrive during that wait are thrown away. It then sums the next 16 fresh samples and divides the sum by 16 with a right shift of 4. It stores the difference, mid-scale minus that average, in a signed register. That register keeps its value until the next calibration completes.

Outside calibration, every incoming sample is passed on one cycle later with the stored offset added. The battery-sense channel (channel 7) can be selected for battery mode. In that mode both the raw reading and the offset go through a gain before they are added. The gain is ×3 when the divider select is 1, and ×3/2 when it is 0. The halving truncates toward zero.

Top module: `cal_offset_comp`

## Requirements
- R1: After reset, `cal_busy`, `cal_done` and `res_valid` are 0 and `comp_value` is 0, so results pass through with no correction.
- R2: A `cal_start` pulse while idle sets `cal_busy` from the next cycle. `cal_busy` stays high until the cycle in which `cal_done` is high. A `cal_start` that arrives while busy is ignored and does not restart or lengthen the calibration.
- R3: For the first SETTLE_CYCLES clock edges after the start edge, sample strobes are discarded and do not count toward the 16 samples.
- R4: The next 16 samples after settling are summed. On the edge that takes the 16th sample, `comp_value` becomes 512 minus (sum >> 4) as a signed 11-bit value, `cal_done` goes high for exactly one cycle, and `cal_busy` goes low.
- R5: `comp_value` changes only on the edge that raises `cal_done`. It holds through results and through the settling and accumulation phases of a later calibration.
- R6: While busy, samples produce no result: `res_valid` stays 0.
- R7: While idle, a sample with `smp_valid` high gives `res_valid` high one cycle later, together with `res_chan` equal to its channel and `res_data` equal to the raw value plus `comp_value`.
- R8: When `bat_sense_en` is 1 and the channel is 7, `res_data` is g(raw) + g(`comp_value`). Here g(x) = 3x when `bat_div_sel` is 1, and g(x) = 3x/2 truncated toward zero when it is 0.
- R9: For any other channel, or when `bat_sense_en` is 0, no gain is applied, whatever the value of `bat_div_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_start | input | 1 | One-cycle calibration request |
| bat_sense_en | input | 1 | Enables the battery gain on channel 7 |
| bat_div_sel | input | 1 | Battery gain select: 1 = ×3, 0 = ×3/2 |
| smp_valid | input | 1 | Sample strobe, one per fresh conversion |
| smp_chan | input | 3 | Channel of the sample |
| smp_data | input | 10 | Raw conversion result |
| cal_busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | One-cycle pulse when `comp_value` is updated |
| comp_value | output | 11 | Signed compensating value |
| res_valid | output | 1 | Corrected result strobe |
| res_chan | output | 3 | Channel of the corrected result |
| res_data | output | 14 | Signed corrected result |

## Verification
`cal_busy` rises one edge after the start edge. The 16th counted sample is taken SETTLE_CYCLES+16 edges after the start edge, and `cal_done` and the new `comp_value` appear on that same edge. A corrected result is registered once, so it appears one edge after its sample. The bench changes its inputs 1 ns after each rising edge and reads outputs 1 ns after the edge that is due to produce them. A settling strobe counted one cycle too early or too late shifts the average, and the check on the exact `comp_value` catches it. Directed offsets of 0, 512 and −511 cover the extremes, including the negative half-gain case where truncation toward zero and floor give different answers.

// File: rtl/cal_pkg.sv
package cal_pkg;

   typedef enum logic [1:0] {
      CAL_IDLE   = 2'd0,
      CAL_SETTLE = 2'd1,
      CAL_ACCUM  = 2'd2
   } cal_state_e;

endpackage

// File: rtl/cal_settle_timer.sv
module cal_settle_timer #(
   parameter int SETTLE_CYCLES = 100000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic expired
);

   localparam int CW = $clog2(SETTLE_CYCLES + 1);
   localparam logic [CW-1:0] LOAD_VAL = CW'(SETTLE_CYCLES - 1);

   generate
      if (SETTLE_CYCLES < 1) begin : g_bad_settle
         $error("SETTLE_CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= LOAD_VAL;
      else if (run && cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   AST_SETTLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3

endmodule

// File: rtl/cal_accum.sv
module cal_accum #(
   parameter int DATA_W = 10,
   parameter int LOG2_N = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              add,
   input  logic [DATA_W-1:0] data,
   output logic              last,
   output logic [DATA_W-1:0] avg_next
);

   localparam int SUM_W = DATA_W + LOG2_N;

   generate
      if (LOG2_N < 1) begin : g_bad_n
         $error("LOG2_N must be at least 1");
      end
   endgenerate

   logic [SUM_W-1:0]  sum_q;
   logic [SUM_W-1:0]  sum_next;
   logic [LOG2_N-1:0] cnt_q;

   assign sum_next = sum_q + SUM_W'(data);
   assign avg_next = sum_next[SUM_W-1:LOG2_N];
   assign last     = (cnt_q == {LOG2_N{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q <= '0;
         cnt_q <= '0;
      end else if (clear) begin
         sum_q <= '0;
         cnt_q <= '0;
      end else if (add) begin
         sum_q <= sum_next;
         cnt_q <= cnt_q + 1'b1;
      end
   end

   AST_ACC_MONO: assert property (@(posedge clk) disable iff (!rst_n)
      (add && !clear) |=> (sum_q >= $past(sum_q))); // R4

endmodule

// File: rtl/cal_gain.sv
module cal_gain #(
   parameter int IN_W = 11
) (
   input  logic signed [IN_W-1:0] x,
   input  logic                   en,
   input  logic                   div_sel,
   output logic signed [IN_W+1:0] y
);

   logic signed [IN_W+1:0] x_ext;
   logic signed [IN_W+1:0] triple;
   logic signed [IN_W+1:0] adj;
   logic signed [IN_W+1:0] half;

   assign x_ext  = {{2{x[IN_W-1]}}, x};
   assign triple = x_ext + (x_ext <<< 1);
   // add one before the arithmetic shift on negatives: truncation toward zero
   assign adj    = triple + $signed({{(IN_W+1){1'b0}}, triple[IN_W+1]});
   assign half   = adj >>> 1;

   always_comb begin
      if (!en)
         y = x_ext;
      else if (div_sel)
         y = triple;
      else
         y = half;
   end

endmodule

// File: rtl/cal_offset_comp.sv
module cal_offset_comp #(
   parameter int DATA_W        = 10,
   parameter int CH_W          = 3,
   parameter int LOG2_N        = 4,
   parameter int SETTLE_CYCLES = 100000,
   parameter int BAT_CHAN      = 7
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cal_start,
   input  logic                     bat_sense_en,
   input  logic                     bat_div_sel,
   input  logic                     smp_valid,
   input  logic [CH_W-1:0]          smp_chan,
   input  logic [DATA_W-1:0]        smp_data,
   output logic                     cal_busy,
   output logic                     cal_done,
   output logic signed [DATA_W:0]   comp_value,
   output logic                     res_valid,
   output logic [CH_W-1:0]          res_chan,
   output logic signed [DATA_W+3:0] res_data
);

   import cal_pkg::*;

   localparam int COMP_W = DATA_W + 1;
   localparam int GAIN_W = COMP_W + 2;
   localparam int RES_W  = DATA_W + 4;
   localparam logic signed [COMP_W-1:0] MID = COMP_W'(1 << (DATA_W - 1));

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (BAT_CHAN >= (1 << CH_W)) begin : g_bad_chan
         $error("BAT_CHAN does not fit in CH_W");
      end
   endgenerate

   cal_state_e state_q;
   logic       settle_done;
   logic       acc_last;
   logic [DATA_W-1:0] acc_avg;
   logic       start_ok;
   logic       take_smp;

   assign start_ok = (state_q == CAL_IDLE) && cal_start;
   assign take_smp = (state_q == CAL_ACCUM) && smp_valid;
   assign cal_busy = (state_q != CAL_IDLE);

   cal_settle_timer #(
      .SETTLE_CYCLES(SETTLE_CYCLES)
   ) u_settle (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (start_ok),
      .run     (state_q == CAL_SETTLE),
      .expired (settle_done)
   );

   cal_accum #(
      .DATA_W(DATA_W),
      .LOG2_N(LOG2_N)
   ) u_accum (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (start_ok),
      .add      (take_smp),
      .data     (smp_data),
      .last     (acc_last),
      .avg_next (acc_avg)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= CAL_IDLE;
         cal_done   <= 1'b0;
         comp_value <= '0;
      end else begin
         cal_done <= 1'b0;
         unique case (state_q)
            CAL_IDLE:   if (cal_start) state_q <= CAL_SETTLE;
            CAL_SETTLE: if (settle_done) state_q <= CAL_ACCUM;
            CAL_ACCUM: begin
               if (smp_valid && acc_last) begin
                  comp_value <= MID - $signed({1'b0, acc_avg});
                  cal_done   <= 1'b1;
                  state_q    <= CAL_IDLE;
               end
            end
            default:    state_q <= CAL_IDLE;
         endcase
      end
   end

   // correction path: operand 0 is the raw sample, operand 1 the offset
   logic signed [COMP_W-1:0] g_in  [2];
   logic signed [GAIN_W-1:0] g_out [2];
   logic                     bat_hit;

   assign bat_hit = bat_sense_en && (smp_chan == CH_W'(BAT_CHAN));
   assign g_in[0] = $signed({1'b0, smp_data});
   assign g_in[1] = comp_value;

   generate
      for (genvar gi = 0; gi < 2; gi++) begin : g_gain
         cal_gain #(
            .IN_W(COMP_W)
         ) u_gain (
            .x       (g_in[gi]),
            .en      (bat_hit),
            .div_sel (bat_div_sel),
            .y       (g_out[gi])
         );
      end
   endgenerate

   logic signed [RES_W-1:0] corrected;
   assign corrected = {g_out[0][GAIN_W-1], g_out[0]} + {g_out[1][GAIN_W-1], g_out[1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_chan  <= '0;
         res_data  <= '0;
      end else begin
         res_valid <= smp_valid && (state_q == CAL_IDLE);
         if (smp_valid && state_q == CAL_IDLE) begin
            res_chan <= smp_chan;
            res_data <= corrected;
         end
      end
   end

   AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cal_busy) |-> $past(cal_start)); // R2
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      cal_done |=> !cal_done); // R4
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      cal_done |-> (!cal_busy && $past(cal_busy))); // R4
   AST_COMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(comp_value) |-> cal_done); // R5
   AST_NO_RES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !$past(cal_busy)); // R6

endmodule

// File: tb/cal_offset_comp_bench.sv
`timescale 1ns/1ps
module cal_offset_comp_bench;

   localparam int S = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cal_start = 1'b0;
   logic              bat_sense_en = 1'b0;
   logic              bat_div_sel = 1'b0;
   logic              smp_valid = 1'b0;
   logic [2:0]        smp_chan = '0;
   logic [9:0]        smp_data = '0;
   logic              cal_busy;
   logic              cal_done;
   logic signed [10:0] comp_value;
   logic              res_valid;
   logic [2:0]        res_chan;
   logic signed [13:0] res_data;

   int n_chk = 0;
   int n_fail = 0;
   int cur_comp = 0;

   always #2.5 clk = ~clk;

   cal_offset_comp #(
      .SETTLE_CYCLES(S)
   ) u_cal_offset_comp (
      .clk, .rst_n, .cal_start, .bat_sense_en, .bat_div_sel,
      .smp_valid, .smp_chan, .smp_data, .cal_busy, .cal_done,
      .comp_value, .res_valid, .res_chan, .res_data
   );

   function automatic int gain(int x, bit en, bit d);
      if (!en) return x;
      if (d) return 3 * x;
      return (3 * x) / 2;
   endfunction

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic run_cal(input int smp[16], input bit poke);
      int sum = 0;
      int exp_c;
      cal_start = 1'b1;
      step();
      cal_start = 1'b0;
      chk("R2 busy after start", cal_busy, 1);
      for (int i = 0; i < S; i++) begin
         smp_valid = 1'b1;
         smp_chan  = 3'd0;
         smp_data  = (i % 2) ? 10'd1023 : 10'd0;
         if (poke && i == 2) cal_start = 1'b1;
         step();
         cal_start = 1'b0;
         if (i == 1) begin
            chk("R6 no result while busy", res_valid, 0);
            chk("R5 comp held during settle", comp_value, cur_comp);
         end
      end
      for (int i = 0; i < 16; i++) begin
         smp_valid = 1'b1;
         smp_data  = 10'(smp[i]);
         sum += smp[i];
         step();
         if (i == 14) begin
            chk("R4 no done before 16th sample", cal_done, 0);
            chk("R2 busy before 16th sample", cal_busy, 1);
         end
      end
      smp_valid = 1'b0;
      exp_c = 512 - (sum >> 4);
      chk("R4 done pulse", cal_done, 1);
      chk("R4 busy drops with done", cal_busy, 0);
      chk("R4 comp value", comp_value, exp_c);
      cur_comp = exp_c;
      step();
      chk("R4 done single cycle", cal_done, 0);
      chk("R5 comp holds", comp_value, cur_comp);
   endtask

   task automatic do_res(int raw, int ch, bit en, bit d, string req);
      bit hit = en && (ch == 7);
      smp_valid    = 1'b1;
      smp_data     = 10'(raw);
      smp_chan     = 3'(ch);
      bat_sense_en = en;
      bat_div_sel  = d;
      step();
      smp_valid = 1'b0;
      chk({req, " res_valid"}, res_valid, 1);
      chk({req, " res_chan"}, res_chan, ch);
      chk({req, " res_data"}, res_data, gain(raw, hit, d) + gain(cur_comp, hit, d));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      report();
      $finish;
   end

   initial begin
      int s[16];
      void'($urandom(32'd7351));
      #1;
      chk("R1 busy in reset", cal_busy, 0);
      repeat (3) step();
      rst_n = 1'b1;
      step();
      chk("R1 busy", cal_busy, 0);
      chk("R1 done", cal_done, 0);
      chk("R1 comp", comp_value, 0);
      chk("R1 res_valid", res_valid, 0);
      do_res(100, 2, 1'b0, 1'b0, "R7 uncalibrated");

      foreach (s[i]) s[i] = 512;
      run_cal(s, 1'b0);
      foreach (s[i]) s[i] = 0;
      run_cal(s, 1'b1);
      do_res(200, 7, 1'b1, 1'b1, "R8 x3");
      do_res(300, 7, 1'b1, 1'b0, "R8 x3/2");
      do_res(40, 3, 1'b0, 1'b0, "R7 plain");
      foreach (s[i]) s[i] = 1023;
      run_cal(s, 1'b0);
      chk("R4 negative offset", comp_value, -511);
      do_res(0, 7, 1'b1, 1'b0, "R8 truncation toward zero");
      do_res(1, 7, 1'b1, 1'b0, "R8 odd negative");
      do_res(500, 7, 1'b0, 1'b1, "R9 battery off");
      do_res(500, 3, 1'b1, 1'b1, "R9 other channel");

      for (int k = 0; k < 5; k++) begin
         foreach (s[i]) s[i] = $urandom_range(440, 600);
         run_cal(s, 1'($urandom_range(0, 1)));
         for (int j = 0; j < 10; j++) begin
            int ch = $urandom_range(0, 7);
            if ($urandom_range(0, 1) == 1) ch = 7;
            do_res($urandom_range(0, 1023), ch, 1'($urandom_range(0, 1)),
                   1'($urandom_range(0, 1)), "R8 R9 random");
         end
         chk("R5 comp held over results", comp_value, cur_comp);
      end

      report();
      $finish;
   end

endmodule